// File: doc/BRIEF.md
# Host Mailbox Port on a Multiplexed Byte Bus

This block is a slave on an 8-bit host bus that carries addresses and data on the same lines. The host first places a register address on the bus and marks it with an address strobe. It then reads or writes that register using an active-low chip select with active-low read and write strobes. Behind the register window are two fixed-size mailboxes of 61 bytes each. One mailbox carries messages from the host to the device. The other carries messages from the device to the host.

The host fills the outbound mailbox through an auto-incrementing data port and hands the message over by writing its length. The mailbox then stays owned by the device until the device reports that it has consumed the message. In the other direction, the device fills the inbound mailbox through a byte-wide port and posts it with a length. The host is then told through an open-drain, active-low interrupt, and releases the mailbox with an acknowledge command. The interrupt stays asserted while any mailbox event is pending. All host strobes are resynchronised to the block clock, so the host must hold each strobe phase for several clock periods.

Top module: `mbx_host_port`

## Requirements
- R1: The register address is taken from the bus when the address strobe falls. The map is: 0x00 outbound data, 0x01 outbound length, 0x02 status, 0x03 command, 0x04 inbound data and 0x05 inbound length. A read of any other address, or of 0x00, returns 0x00.
- R2: The bus output enable is high only while chip select and read strobe are both low.
- R3: Each write to 0x00 stores a byte at the next outbound index. Writing 0x01 with a length of 61 or less commits the message, resets the index and sets status bit 0 (busy). The device side then sees the availability flag, the length and the stored bytes, and 0x01 reads back the length.
- R4: A length above 61, a write to 0x01 while busy, or a data write while busy or after 61 bytes is rejected. Each of these sets status bit 3 (error) and leaves the mailbox contents and busy state unchanged.
- R5: A device consume pulse while busy clears busy and sets status bit 2 (freed).
- R6: A device post with a length of 61 or less, while the inbound mailbox is free, sets status bit 1 (pending). The host then reads the length at 0x05 and the bytes in order from 0x04, with the index advancing on each completed read.
- R7: A command write with bit 0 set clears pending, rewinds the inbound index and frees the mailbox. The interrupt output (1 = pulling the line low) is asserted exactly while pending or freed is set.
- R8: While pending is set, device writes and posts to the inbound mailbox are ignored.
- R9: A command write with bit 1 set clears freed, and one with bit 2 set clears error.
- R10: After reset, status reads 0x00, the interrupt and the bus output enable are off, and no outbound message is available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_in | input | 8 | Address/data bus, receive side |
| ad_out | output | 8 | Address/data bus, drive side |
| ad_oe | output | 1 | Bus drive enable |
| ale | input | 1 | Address strobe, high while an address is on the bus |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| irq_pull_low | output | 1 | Open-drain interrupt; 1 pulls the line low |
| dev_h2d_avail | output | 1 | Outbound message waiting for the device |
| dev_h2d_len | output | 6 | Length of the outbound message |
| dev_h2d_idx | input | 6 | Device read index into the outbound mailbox |
| dev_h2d_data | output | 8 | Outbound byte at dev_h2d_idx |
| dev_h2d_done | input | 1 | Device has consumed the outbound message |
| dev_d2h_we | input | 1 | Device write strobe into the inbound mailbox |
| dev_d2h_idx | input | 6 | Device write index |
| dev_d2h_data | input | 8 | Device write byte |
| dev_d2h_len | input | 6 | Length posted with dev_d2h_post |
| dev_d2h_post | input | 1 | Device posts the inbound message |
| dev_d2h_busy | output | 1 | Inbound mailbox still held by the host |

## Verification
Each host strobe edge passes through two synchroniser flops and one edge flop. The state it causes changes on the edge after that, so results are due about four clock cycles after the pin moves. The bench holds every strobe phase for six cycles and samples only after the hold. Device pulses are applied for one cycle at a falling edge, and their flags are checked a full cycle later. The bus enable and read data are combinational from the pins and the latched address, so they are sampled two cycles into the read phase.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam logic [7:0] REG_H2D_DATA = 8'h00;
   localparam logic [7:0] REG_H2D_LEN  = 8'h01;
   localparam logic [7:0] REG_STATUS   = 8'h02;
   localparam logic [7:0] REG_CMD      = 8'h03;
   localparam logic [7:0] REG_D2H_DATA = 8'h04;
   localparam logic [7:0] REG_D2H_LEN  = 8'h05;

   localparam int ST_BUSY  = 0;
   localparam int ST_PEND  = 1;
   localparam int ST_FREED = 2;
   localparam int ST_ERR   = 3;

   localparam int CMD_ACK       = 0;
   localparam int CMD_CLR_FREED = 1;
   localparam int CMD_CLR_ERR   = 2;
endpackage

// File: rtl/mbx_strobe_sync.sv
module mbx_strobe_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic level,
   output logic rise,
   output logic fall
);
   logic prev_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign level = raw;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
            else        chain_q <= {chain_q[STAGES-2:0], raw};
         end
         assign level = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RESET_VAL;
      else        prev_q <= level;
   end

   assign rise = level & ~prev_q;
   assign fall = ~level & prev_q;
endmodule

// File: rtl/mbx_ram.sv
module mbx_ram #(
   parameter int DEPTH = 61,
   parameter int DW    = 8,
   parameter int IW    = 6
) (
   input  logic          clk,
   input  logic          we,
   input  logic [IW-1:0] widx,
   input  logic [DW-1:0] wdata,
   input  logic [IW-1:0] ridx,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we && (int'(widx) < DEPTH)) mem[widx] <= wdata;
   end

   assign rdata = (int'(ridx) < DEPTH) ? mem[ridx] : '0;
endmodule

// File: rtl/mbx_host_port.sv
module mbx_host_port
   import mbx_pkg::*;
#(
   parameter int DEPTH       = 61,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter int IW          = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] ad_in,
   output logic [DW-1:0] ad_out,
   output logic          ad_oe,
   input  logic          ale,
   input  logic          cs_n,
   input  logic          rd_n,
   input  logic          wr_n,
   output logic          irq_pull_low,
   output logic          dev_h2d_avail,
   output logic [IW-1:0] dev_h2d_len,
   input  logic [IW-1:0] dev_h2d_idx,
   output logic [DW-1:0] dev_h2d_data,
   input  logic          dev_h2d_done,
   input  logic          dev_d2h_we,
   input  logic [IW-1:0] dev_d2h_idx,
   input  logic [DW-1:0] dev_d2h_data,
   input  logic [IW-1:0] dev_d2h_len,
   input  logic          dev_d2h_post,
   output logic          dev_d2h_busy
);
   localparam logic [DW-1:0] DEPTH_B = DW'(DEPTH);
   localparam logic [IW-1:0] DEPTH_I = IW'(DEPTH);

   generate
      if (DW != 8)                          begin : g_bad_dw    $error("DW must be 8"); end
      if (DEPTH < 1 || DEPTH > 255)         begin : g_bad_depth $error("DEPTH out of range"); end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync $error("SYNC_STAGES 0..3"); end
   endgenerate

   logic ale_lvl, ale_rise, ale_fall;
   logic cs_lvl, cs_rise, cs_fall;
   logic rd_lvl, rd_rise, rd_fall;
   logic wr_lvl, wr_rise, wr_fall;

   mbx_strobe_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_ale_sync (
      .clk(clk), .rst_n(rst_n), .raw(ale), .level(ale_lvl), .rise(ale_rise), .fall(ale_fall));
   mbx_strobe_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cs_sync (
      .clk(clk), .rst_n(rst_n), .raw(cs_n), .level(cs_lvl), .rise(cs_rise), .fall(cs_fall));
   mbx_strobe_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_rd_sync (
      .clk(clk), .rst_n(rst_n), .raw(rd_n), .level(rd_lvl), .rise(rd_rise), .fall(rd_fall));
   mbx_strobe_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_wr_sync (
      .clk(clk), .rst_n(rst_n), .raw(wr_n), .level(wr_lvl), .rise(wr_rise), .fall(wr_fall));

   logic [DW-1:0] addr_q;
   logic          wr_ev, rd_ev;
   logic          h2d_busy_q, d2h_pend_q, h2d_freed_q, err_q;
   logic [IW-1:0] h2d_len_q, h2d_widx_q, d2h_len_q, d2h_ridx_q;
   logic          h2d_we, h2d_data_bad, h2d_len_ok, h2d_len_bad;
   logic          d2h_we_ok, d2h_post_ok, cmd_ev, d2h_adv;
   logic [DW-1:0] d2h_rdata, status_byte;

   assign wr_ev = wr_rise & ~cs_lvl;
   assign rd_ev = rd_rise & ~cs_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        addr_q <= '0;
      else if (ale_fall) addr_q <= ad_in;
   end

   // outbound mailbox
   assign h2d_we       = wr_ev && addr_q == REG_H2D_DATA && !h2d_busy_q && h2d_widx_q < DEPTH_I;
   assign h2d_data_bad = wr_ev && addr_q == REG_H2D_DATA && !h2d_we;
   assign h2d_len_ok   = wr_ev && addr_q == REG_H2D_LEN && !h2d_busy_q && ad_in <= DEPTH_B;
   assign h2d_len_bad  = wr_ev && addr_q == REG_H2D_LEN && !h2d_len_ok;
   assign cmd_ev       = wr_ev && addr_q == REG_CMD;

   mbx_ram #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_h2d_ram (
      .clk(clk), .we(h2d_we), .widx(h2d_widx_q), .wdata(ad_in),
      .ridx(dev_h2d_idx), .rdata(dev_h2d_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h2d_busy_q  <= 1'b0;
         h2d_len_q   <= '0;
         h2d_widx_q  <= '0;
         h2d_freed_q <= 1'b0;
         err_q       <= 1'b0;
      end else begin
         if (h2d_we) h2d_widx_q <= h2d_widx_q + 1'b1;
         if (h2d_len_ok) begin
            h2d_busy_q <= 1'b1;
            h2d_len_q  <= ad_in[IW-1:0];
            h2d_widx_q <= '0;
         end
         if (cmd_ev && ad_in[CMD_CLR_FREED]) h2d_freed_q <= 1'b0;
         if (cmd_ev && ad_in[CMD_CLR_ERR])   err_q       <= 1'b0;
         if (h2d_busy_q && dev_h2d_done) begin
            h2d_busy_q  <= 1'b0;
            h2d_freed_q <= 1'b1;
         end
         if (h2d_data_bad || h2d_len_bad) err_q <= 1'b1;
      end
   end

   // inbound mailbox
   assign d2h_we_ok   = dev_d2h_we && !d2h_pend_q;
   assign d2h_post_ok = dev_d2h_post && !d2h_pend_q && dev_d2h_len <= DEPTH_I;
   assign d2h_adv     = rd_ev && addr_q == REG_D2H_DATA && d2h_ridx_q < DEPTH_I;

   mbx_ram #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_d2h_ram (
      .clk(clk), .we(d2h_we_ok), .widx(dev_d2h_idx), .wdata(dev_d2h_data),
      .ridx(d2h_ridx_q), .rdata(d2h_rdata));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d2h_pend_q <= 1'b0;
         d2h_len_q  <= '0;
         d2h_ridx_q <= '0;
      end else if (d2h_post_ok) begin
         d2h_pend_q <= 1'b1;
         d2h_len_q  <= dev_d2h_len;
         d2h_ridx_q <= '0;
      end else if (cmd_ev && ad_in[CMD_ACK]) begin
         d2h_pend_q <= 1'b0;
         d2h_ridx_q <= '0;
      end else if (d2h_adv) begin
         d2h_ridx_q <= d2h_ridx_q + 1'b1;
      end
   end

   // host read path
   always_comb begin
      status_byte           = '0;
      status_byte[ST_BUSY]  = h2d_busy_q;
      status_byte[ST_PEND]  = d2h_pend_q;
      status_byte[ST_FREED] = h2d_freed_q;
      status_byte[ST_ERR]   = err_q;
      case (addr_q)
         REG_H2D_LEN:  ad_out = DW'(h2d_len_q);
         REG_STATUS:   ad_out = status_byte;
         REG_D2H_DATA: ad_out = d2h_rdata;
         REG_D2H_LEN:  ad_out = DW'(d2h_len_q);
         default:      ad_out = '0;
      endcase
   end

   assign ad_oe         = ~cs_n & ~rd_n;
   assign irq_pull_low  = d2h_pend_q | h2d_freed_q;
   assign dev_h2d_avail = h2d_busy_q;
   assign dev_h2d_len   = h2d_len_q;
   assign dev_d2h_busy  = d2h_pend_q;
endmodule

// File: rtl/mbx_host_port_chk.sv
module mbx_host_port_chk #(
   parameter int DEPTH = 61,
   parameter int IW    = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_n,
   input logic          rd_n,
   input logic          ad_oe,
   input logic          irq_pull_low,
   input logic          h2d_busy,
   input logic          h2d_freed,
   input logic          d2h_pend,
   input logic          dev_h2d_done,
   input logic          dev_d2h_post,
   input logic [IW-1:0] dev_d2h_len,
   input logic [IW-1:0] h2d_len,
   input logic [IW-1:0] d2h_len
);
   a_r2_drive_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> (!cs_n && !rd_n));

   a_r4_len_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(h2d_len) <= DEPTH);

   a_r5_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (h2d_busy && dev_h2d_done) |=> (!h2d_busy && h2d_freed));

   a_r6_post_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (!d2h_pend && dev_d2h_post && int'(dev_d2h_len) <= DEPTH) |=> (d2h_pend && irq_pull_low));

   a_r7_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(d2h_pend) && !h2d_freed) |-> !irq_pull_low);

   a_r8_len_held: assert property (@(posedge clk) disable iff (!rst_n)
      (d2h_pend && $past(d2h_pend)) |-> $stable(d2h_len));
endmodule

bind mbx_host_port mbx_host_port_chk #(.DEPTH(DEPTH), .IW(IW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .ad_oe(ad_oe),
   .irq_pull_low(irq_pull_low), .h2d_busy(h2d_busy_q), .h2d_freed(h2d_freed_q),
   .d2h_pend(d2h_pend_q), .dev_h2d_done(dev_h2d_done), .dev_d2h_post(dev_d2h_post),
   .dev_d2h_len(dev_d2h_len), .h2d_len(h2d_len_q), .d2h_len(d2h_len_q));

// File: tb/mbx_host_port_tb.sv
module mbx_host_port_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ad_in = 8'h00;
   logic [7:0] ad_out;
   logic       ad_oe, ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic       irq_pull_low, dev_h2d_avail, dev_h2d_done = 1'b0;
   logic [5:0] dev_h2d_len, dev_h2d_idx = 6'd0;
   logic [7:0] dev_h2d_data;
   logic       dev_d2h_we = 1'b0, dev_d2h_post = 1'b0, dev_d2h_busy;
   logic [5:0] dev_d2h_idx = 6'd0, dev_d2h_len = 6'd0;
   logic [7:0] dev_d2h_data = 8'h00;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   always #5 clk = ~clk;

   mbx_host_port u_dut (
      .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
      .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .irq_pull_low(irq_pull_low),
      .dev_h2d_avail(dev_h2d_avail), .dev_h2d_len(dev_h2d_len), .dev_h2d_idx(dev_h2d_idx),
      .dev_h2d_data(dev_h2d_data), .dev_h2d_done(dev_h2d_done), .dev_d2h_we(dev_d2h_we),
      .dev_d2h_idx(dev_d2h_idx), .dev_d2h_data(dev_d2h_data), .dev_d2h_len(dev_d2h_len),
      .dev_d2h_post(dev_d2h_post), .dev_d2h_busy(dev_d2h_busy));

   // {is_read, addr, data, expected}
   localparam int NV = 10;
   localparam logic [24:0] VEC [NV] = '{
      {1'b0, 8'h00, 8'h11, 8'h00},
      {1'b0, 8'h00, 8'h22, 8'h00},
      {1'b0, 8'h00, 8'h33, 8'h00},
      {1'b0, 8'h01, 8'h03, 8'h00},
      {1'b1, 8'h02, 8'h00, 8'h01},
      {1'b1, 8'h01, 8'h00, 8'h03},
      {1'b0, 8'h00, 8'h44, 8'h00},
      {1'b1, 8'h02, 8'h00, 8'h09},
      {1'b0, 8'h03, 8'h04, 8'h00},
      {1'b1, 8'h02, 8'h00, 8'h01}
   };

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic set_addr(input logic [7:0] a);
      @(negedge clk);
      ad_in = a; ale = 1'b1;
      wait_cyc(6);
      ale = 1'b0;
      wait_cyc(6);
   endtask

   task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
      set_addr(a);
      ad_in = d; cs_n = 1'b0; wr_n = 1'b0;
      wait_cyc(6);
      wr_n = 1'b1;
      wait_cyc(6);
      cs_n = 1'b1;
      wait_cyc(4);
   endtask

   task automatic host_rd(input logic [7:0] a, output logic [7:0] d);
      set_addr(a);
      cs_n = 1'b0; rd_n = 1'b0;
      wait_cyc(2);
      d = ad_out;
      wait_cyc(4);
      rd_n = 1'b1;
      wait_cyc(6);
      cs_n = 1'b1;
      wait_cyc(4);
   endtask

   task automatic dev_pulse_done();
      @(negedge clk);
      dev_h2d_done = 1'b1;
      @(negedge clk);
      dev_h2d_done = 1'b0;
      wait_cyc(2);
   endtask

   task automatic dev_write(input logic [5:0] i, input logic [7:0] d);
      @(negedge clk);
      dev_d2h_we = 1'b1; dev_d2h_idx = i; dev_d2h_data = d;
      @(negedge clk);
      dev_d2h_we = 1'b0;
   endtask

   task automatic dev_post(input logic [5:0] n);
      @(negedge clk);
      dev_d2h_post = 1'b1; dev_d2h_len = n;
      @(negedge clk);
      dev_d2h_post = 1'b0;
      wait_cyc(2);
   endtask

   initial begin
      logic [7:0] rv;
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(4);

      // R10 reset state
      chk("R10 irq", {7'd0, irq_pull_low}, 8'h00);
      chk("R10 oe", {7'd0, ad_oe}, 8'h00);
      chk("R10 avail", {7'd0, dev_h2d_avail}, 8'h00);
      host_rd(8'h02, rv);
      chk("R10 status", rv, 8'h00);

      // R3 / R4 / R9 vector table
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][24]) begin
            host_rd(VEC[i][23:16], rv);
            chk($sformatf("R3/R4/R9 vec%0d", i), rv, VEC[i][7:0]);
         end else begin
            host_wr(VEC[i][23:16], VEC[i][15:8]);
         end
      end

      // R3 device sees message
      chk("R3 avail", {7'd0, dev_h2d_avail}, 8'h01);
      chk("R3 len", {2'd0, dev_h2d_len}, 8'h03);
      for (int i = 0; i < 3; i++) begin
         dev_h2d_idx = 6'(i);
         #1;
         chk($sformatf("R3 byte%0d", i), dev_h2d_data, 8'(8'h11 * (i + 1)));
      end

      // R5 consume
      dev_pulse_done();
      chk("R5 avail", {7'd0, dev_h2d_avail}, 8'h00);
      chk("R7 irq freed", {7'd0, irq_pull_low}, 8'h01);
      host_rd(8'h02, rv);
      chk("R5 status", rv, 8'h04);
      host_wr(8'h03, 8'h02);
      host_rd(8'h02, rv);
      chk("R9 clear freed", rv, 8'h00);
      chk("R7 irq off", {7'd0, irq_pull_low}, 8'h00);

      // R4 over-length
      host_wr(8'h01, 8'd62);
      host_rd(8'h02, rv);
      chk("R4 too long", rv, 8'h08);
      chk("R4 not busy", {7'd0, dev_h2d_avail}, 8'h00);
      host_wr(8'h03, 8'h04);

      // R1 unmapped and data-port read
      host_rd(8'h7F, rv);
      chk("R1 unmapped", rv, 8'h00);
      host_rd(8'h00, rv);
      chk("R1 data port read", rv, 8'h00);

      // R2 bus drive qualification
      @(negedge clk); cs_n = 1'b0; rd_n = 1'b1; #1;
      chk("R2 cs only", {7'd0, ad_oe}, 8'h00);
      rd_n = 1'b0; #1;
      chk("R2 both low", {7'd0, ad_oe}, 8'h01);
      cs_n = 1'b1; #1;
      chk("R2 rd only", {7'd0, ad_oe}, 8'h00);
      rd_n = 1'b1;
      wait_cyc(8);

      // R6 inbound message
      for (int i = 0; i < 5; i++) dev_write(6'(i), 8'(8'hA0 + i));
      dev_post(6'd5);
      chk("R6 busy", {7'd0, dev_d2h_busy}, 8'h01);
      chk("R7 irq pend", {7'd0, irq_pull_low}, 8'h01);
      host_rd(8'h02, rv);
      chk("R6 status", rv, 8'h02);

      // R8 ignored while pending
      dev_write(6'd0, 8'hEE);
      dev_post(6'd2);
      host_rd(8'h05, rv);
      chk("R8 len kept", rv, 8'h05);
      for (int i = 0; i < 5; i++) begin
         host_rd(8'h04, rv);
         chk($sformatf("R6/R8 byte%0d", i), rv, 8'(8'hA0 + i));
      end

      // R7 acknowledge
      host_wr(8'h03, 8'h01);
      chk("R7 busy off", {7'd0, dev_d2h_busy}, 8'h00);
      chk("R7 irq off after ack", {7'd0, irq_pull_low}, 8'h00);
      host_rd(8'h02, rv);
      chk("R7 status", rv, 8'h00);

      if (!ended) begin
         ended = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule